// File: doc/BRIEF.md
# Six-Phase Instruction Fetch Sequencer

This block is the front end of a small multi-cycle processor. It holds a 32-bit program counter and a 256-word instruction store whose contents are computed when the design starts. Each instruction takes a fixed round of six timing phases.

In phase 0 the word at the current program counter is captured into an instruction register, and its top byte is presented as the opcode. In phase 4 the opcode is checked for the halt code. A halt freezes the sequencer until reset. Any other opcode raises a one-cycle strobe that a display register uses as its load enable.

Phase 5 is the only phase that moves the program counter. It either takes a jump target supplied by surrounding logic or advances by one. Load has priority over increment, so increment may be requested on every update.

The ALU, the register file and the wider opcode decode sit outside this block. They reach it only through the jump request, the jump target and the opcode outputs.

Top module: `fetch_sequencer`

## Requirements
- R1: While `rst` is high, and immediately when it rises, `pc` is 0x00000000, `phase_onehot` is 6'b000001 (phase 0), `instr` is 0, and both `halted` and `disp_load` are 0.
- R2: `phase_onehot` has exactly one bit set; bit k means phase k. While not halted it moves up one bit per clock and wraps from phase 5 to phase 0.
- R3: A clock edge taken in phase 0 loads `instr` with the store word at index `pc[7:0]`, where word(a) = {a ^ 8'h5A, 8'hC3, a, ~a}. `instr` holds its value on every other edge.
- R4: `pc` changes only on a clock edge taken in phase 5. A full update happens in that one clock.
- R5: On a phase-5 edge with `jump_req` high, `pc` takes the value of `jump_target`, even though increment is also requested.
- R6: On a phase-5 edge with `jump_req` low, `pc` becomes `pc + 1` modulo 2^32, so 0xFFFFFFFF is followed by 0. `jump_req` has no effect in phases 0 to 4.
- R7: `disp_load` is high exactly during phase 4 when the sequencer is not halted and `opcode` is not 8'hFF.
- R8: A phase-4 edge with `opcode` equal to 8'hFF sets `halted`. From then until reset, `halted` stays high, `phase_onehot` stays at phase 4, and `pc`, `instr` and `disp_load` (low) stay constant whatever `jump_req` does.
- R9: `opcode` always equals `instr[31:24]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset, clears all state asynchronously |
| jump_req | input | 1 | Take `jump_target` at the next phase-5 update |
| jump_target | input | 32 | Program counter load value |
| pc | output | 32 | Program counter |
| phase_onehot | output | 6 | Current timing phase, one-hot |
| instr | output | 32 | Latched instruction word |
| opcode | output | 8 | Top byte of the latched instruction |
| disp_load | output | 1 | One-cycle load strobe for the display register |
| halted | output | 1 | Sequencer frozen by the halt opcode |

## Verification
A phase ring that drops or doubles its bit shows up at once in `phase_onehot`, and within one instruction as a missing or extra `pc` step. A program counter that takes a step in the wrong phase, or reads the wrong priority between load and increment, differs from the reference on the very next clock. So does a fetch register loaded in the wrong phase, which makes `instr` depart from the computed store word. Halt detection that fails shows as a `disp_load` pulse at index 0xA5, and a halt that does not stick shows as `pc` moving afterwards. Each of these is visible within six clocks.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    localparam int PC_W    = 32;
    localparam int ROM_AW  = 8;
    localparam int OP_W    = 8;
    localparam int N_PHASE = 6;
    localparam logic [OP_W-1:0] HALT_OP = 8'hFF;

    // phase indices that carry an action
    localparam int PH_FETCH = 0;
    localparam int PH_CHECK = 4;
    localparam int PH_STEP  = 5;

    typedef struct packed {
        logic fetch;   // capture store word
        logic check;   // halt / display decision
        logic step;    // program counter update
    } phase_ctl_t;

    // initial store contents, computed from the index
    function automatic logic [PC_W-1:0] rom_word(input logic [ROM_AW-1:0] a);
        return {a ^ 8'h5A, 8'hC3, a, ~a};
    endfunction
endpackage

// File: rtl/fetch_phase_ring.sv
module fetch_phase_ring #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    output logic [N-1:0] ring
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            ring <= {{(N-1){1'b0}}, 1'b1};
        else if (advance)
            ring <= {ring[N-2:0], ring[N-1]};
    end
endmodule

// File: rtl/fetch_pc_counter.sv
module fetch_pc_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         ld,
    input  logic         inc,
    input  logic         dec,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or posedge clr) begin
        if (clr)
            q <= '0;
        else if (ld)
            q <= d;
        else if (inc)
            q <= q + W'(1);
        else if (dec)
            q <= q - W'(1);
    end
endmodule

// File: rtl/fetch_rom.sv
module fetch_rom
    import fetch_pkg::*;
#(
    parameter int AW = ROM_AW,
    parameter int DW = PC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] dout
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++)
            mem[i] = DW'(rom_word(ROM_AW'(i)));
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            dout <= '0;
        else if (capture)
            dout <= mem[addr];
    end
endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
    import fetch_pkg::*;
#(
    parameter int W        = PC_W,
    parameter int AW       = ROM_AW,
    parameter int OW       = OP_W,
    parameter int NPH      = N_PHASE,
    parameter logic [OW-1:0] HALT_CODE = HALT_OP
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           jump_req,
    input  logic [W-1:0]   jump_target,
    output logic [W-1:0]   pc,
    output logic [NPH-1:0] phase_onehot,
    output logic [W-1:0]   instr,
    output logic [OW-1:0]  opcode,
    output logic           disp_load,
    output logic           halted
);
    phase_ctl_t ctl;
    logic       is_halt_op;
    logic       halt_now;

    assign opcode     = instr[W-1 -: OW];
    assign is_halt_op = (opcode == HALT_CODE);

    always_comb begin
        ctl.fetch = phase_onehot[PH_FETCH] & ~halted;
        ctl.check = phase_onehot[PH_CHECK] & ~halted;
        ctl.step  = phase_onehot[PH_STEP]  & ~halted;
    end

    assign halt_now  = ctl.check & is_halt_op;
    assign disp_load = ctl.check & ~is_halt_op;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            halted <= 1'b0;
        else if (halt_now)
            halted <= 1'b1;
    end

    fetch_phase_ring #(.N(NPH)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .advance (~halted & ~halt_now),
        .ring    (phase_onehot)
    );

    // increment is always requested in the step phase; load wins
    fetch_pc_counter #(.W(W)) u_pc (
        .clk (clk),
        .clr (rst),
        .ld  (ctl.step & jump_req),
        .inc (ctl.step),
        .dec (1'b0),
        .d   (jump_target),
        .q   (pc)
    );

    fetch_rom #(.AW(AW), .DW(W)) u_rom (
        .clk     (clk),
        .rst     (rst),
        .capture (ctl.fetch),
        .addr    (pc[AW-1:0]),
        .dout    (instr)
    );
endmodule

// File: rtl/fetch_sequencer_chk.sv
module fetch_sequencer_chk #(
    parameter int W   = 32,
    parameter int OW  = 8,
    parameter int NPH = 6,
    parameter logic [OW-1:0] HALT_CODE = 8'hFF
) (
    input logic           clk,
    input logic           rst,
    input logic           jump_req,
    input logic [W-1:0]   jump_target,
    input logic [W-1:0]   pc,
    input logic [NPH-1:0] phase_onehot,
    input logic [W-1:0]   instr,
    input logic [OW-1:0]  opcode,
    input logic           disp_load,
    input logic           halted
);
    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_onehot) == 1);

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_onehot[NPH-1] && !halted) |=> phase_onehot[0]);

    assert_instr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !phase_onehot[0] |=> $stable(instr));

    assert_pc_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !phase_onehot[NPH-1] |=> $stable(pc));

    assert_jump_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_onehot[NPH-1] && !halted && jump_req) |=> pc == $past(jump_target));

    assert_step_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_onehot[NPH-1] && !halted && !jump_req) |=> pc == $past(pc) + W'(1));

    assert_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        disp_load |-> (phase_onehot[4] && !halted && opcode != HALT_CODE));

    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc) && $stable(phase_onehot) && $stable(instr) && !disp_load));
endmodule

bind fetch_sequencer fetch_sequencer_chk #(
    .W(W), .OW(OW), .NPH(NPH), .HALT_CODE(HALT_CODE)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .jump_req     (jump_req),
    .jump_target  (jump_target),
    .pc           (pc),
    .phase_onehot (phase_onehot),
    .instr        (instr),
    .opcode       (opcode),
    .disp_load    (disp_load),
    .halted       (halted)
);

// File: tb/fetch_sequencer_bench.sv
module fetch_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        jump_req = 1'b0;
    logic [31:0] jump_target = '0;
    logic [31:0] pc;
    logic [5:0]  phase_onehot;
    logic [31:0] instr;
    logic [7:0]  opcode;
    logic        disp_load;
    logic        halted;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference
    int          m_phase;
    logic [31:0] m_pc;
    logic [31:0] m_instr;
    bit          m_halt;
    bit          in_reset;
    bit          saw_wrap = 0;
    bit          saw_halt = 0;
    int          strobes = 0;
    logic [31:0] prev_pc = '0;

    always #5 clk = ~clk;

    fetch_sequencer u_fetch_sequencer (
        .clk(clk), .rst(rst), .jump_req(jump_req), .jump_target(jump_target),
        .pc(pc), .phase_onehot(phase_onehot), .instr(instr), .opcode(opcode),
        .disp_load(disp_load), .halted(halted)
    );

    function automatic logic [31:0] store_word(input logic [7:0] a);
        logic [7:0] top;
        top = a ^ 8'h5A;
        return {top, 8'hC3, a, ~a};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_phase = 0; m_pc = '0; m_instr = '0; m_halt = 0;
    endtask

    task automatic model_step();
        if (m_halt) return;
        case (m_phase)
            0: m_instr = store_word(m_pc[7:0]);
            4: if (m_instr[31:24] == 8'hFF) m_halt = 1;
            5: m_pc = jump_req ? jump_target : m_pc + 32'd1;
            default: ;
        endcase
        if (!m_halt) m_phase = (m_phase == 5) ? 0 : m_phase + 1;
    endtask

    task automatic compare();
        bit exp_disp;
        string t;
        exp_disp = !m_halt && m_phase == 4 && m_instr[31:24] != 8'hFF;
        t = in_reset ? "R1" : "R2";
        chk(phase_onehot == 6'(1 << m_phase), t, 32'(phase_onehot), 32'(1 << m_phase));
        t = in_reset ? "R1" : "R3";
        chk(instr === m_instr, t, instr, m_instr);
        t = in_reset ? "R1" : "R4/R5/R6 pc";
        chk(pc === m_pc, t, pc, m_pc);
        chk(opcode === instr[31:24], "R9", 32'(opcode), 32'(instr[31:24]));
        t = in_reset ? "R1" : "R7";
        chk(disp_load === exp_disp, t, 32'(disp_load), 32'(exp_disp));
        t = in_reset ? "R1" : "R8";
        chk(halted === m_halt, t, 32'(halted), 32'(m_halt));
        if (disp_load) strobes++;
        if (halted) saw_halt = 1;
        if (prev_pc == 32'hFFFF_FFFF && pc == 32'h0) saw_wrap = 1;
        prev_pc = pc;
    endtask

    initial begin
        model_reset();
        in_reset = 1;
        for (int cyc = 0; cyc < 1000; cyc++) begin
            @(negedge clk);
            compare();
            if (cyc < 3 || (cyc >= 900 && cyc < 903)) begin
                rst = 1; jump_req = 0; in_reset = 1;
                model_reset();
            end else begin
                rst = 0; in_reset = 0;
                if (cyc < 400) begin
                    jump_req = (cyc % 7 == 3);
                    jump_target = {16'h1234, 10'h0, 6'(cyc)};
                end else if (cyc < 460) begin
                    jump_req = (cyc % 7 == 3);
                    jump_target = 32'hFFFF_FFFE;          // R6 wrap corner
                end else if (cyc < 520) begin
                    jump_req = (cyc % 7 == 3);
                    jump_target = 32'h0000_0090;          // heads for halt at 0xA5
                end else if (cyc < 600) begin
                    jump_req = 0;
                end else if (cyc < 900) begin
                    jump_req = (cyc % 3 == 0);            // R8: ignored while halted
                    jump_target = 32'h0000_0011;
                end else begin
                    jump_req = (cyc % 5 == 0);
                    jump_target = 32'h0000_0020;
                end
                model_step();
            end
        end
        @(negedge clk);
        compare();
        chk(saw_wrap, "R6 wrap 0xFFFFFFFF->0", 32'(saw_wrap), 32'd1);
        chk(saw_halt, "R8 halt reached", 32'(saw_halt), 32'd1);
        chk(strobes > 0, "R7 strobes seen", 32'(strobes), 32'd1);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                fails++; checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule